// File: doc/BRIEF.md
# Striped-Lane Vector Adder

This unit executes one element-wise integer vector add at a time, `dst[i] = src_a[i] + src_b[i]`, over a small vector register file. The registers are spread across parallel lanes: element `i` of every register sits in lane `i % LANES`, in row `i / LANES` of that lane's storage. Each lane owns its slice of all registers and a three-stage pipeline (operand read, add, writeback). A full row of `LANES` elements therefore moves through the lanes each cycle, and no interlocks are needed.

A programmable length register sets how many leading elements an instruction touches. Elements at or past that length keep their old contents. A start request that finds the unit idle latches the destination, the two sources and the current length. When the last writeback has landed, `done` pulses for one cycle.

A test port reads or writes any single element, so a bench can load operands and inspect results without a memory path.

Top module: `vadd_lanes`

## Requirements
- R1: A test-port write with `tp_we` high stores `tp_wdata` into element `tp_idx` of register `tp_reg` at the clock edge. `tp_rdata` shows element `tp_idx` of register `tp_reg` one clock edge after the address is presented.
- R2: For every element index `i` below the latched length, the destination receives `(src_a[i] + src_b[i]) mod 2^32`.
- R3: Destination elements with index at or beyond the latched length keep their previous values.
- R4: Let `N` be a nonzero latched length. `done` rises exactly `ceil(N/LANES) + 3` rising edges after the edge that accepts `start`, and stays high for one cycle only.
- R5: A latched length of 0 raises `done` at the accepting edge itself, and no register element changes.
- R6: A write of `vl_wdata` (7 bits) through `vl_we` sets the length register. Any value above 64 is stored as 64.
- R7: A `start` is accepted only while no instruction is in flight and `done` is low. A `start` at any other time has no effect.
- R8: An instruction uses the length register value from its accepting edge. A length write made in that same cycle, or later while the instruction runs, does not change it, and the next instruction sees the new length.
- R9: Reset clears `done`, leaves the unit idle, and sets the length register to 64.
- R10: The destination may be the same register as either source, and the result is still the element-wise sum of the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin an add |
| dst | input | 3 | Destination register index |
| src_a | input | 3 | First source register index |
| src_b | input | 3 | Second source register index |
| vl_we | input | 1 | Length register write enable |
| vl_wdata | input | 7 | New vector length (clamped to 64) |
| done | output | 1 | One-cycle completion pulse |
| tp_we | input | 1 | Test-port element write enable |
| tp_reg | input | 3 | Test-port register index |
| tp_idx | input | 6 | Test-port element index |
| tp_wdata | input | 32 | Test-port write data |
| tp_rdata | output | 32 | Test-port read data, one cycle after the address |

## Verification
Each element row is issued one cycle after the previous row. Its sum is written three edges after issue, and `done` follows one edge after the last write. The bench counts rising edges from the accepting edge to the first cycle in which `done` is seen, and compares that count with `ceil(N/4)+3`, or with 0 for an empty length. It then checks the next cycle for `done` low. Results are read only after `done`. Each test-port read is sampled at the falling edge after the edge that captured its address, which matches the single registered read stage. Length writes and stray starts are placed on counted cycles inside the run, so that each one is known to land while the instruction is in flight.

// File: rtl/vadd_pkg.sv
package vadd_pkg;
  localparam int DEF_LANES = 4;
  localparam int DEF_MAXVL = 64;
  localparam int DEF_NREGS = 8;
  localparam int DEF_DW    = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/vadd_seq.sv
module vadd_seq
  import vadd_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int MAXVL = DEF_MAXVL,
  parameter int NREGS = DEF_NREGS,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROW_W  = $clog2(MAXVL / LANES),
  localparam int VL_W   = $clog2(MAXVL + 1),
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RIDX_W-1:0] dst_in,
  input  logic [RIDX_W-1:0] src_a_in,
  input  logic [RIDX_W-1:0] src_b_in,
  input  logic              vl_we,
  input  logic [VL_W-1:0]   vl_wdata,
  output logic [LANES-1:0]  iss_mask,
  output logic [ROW_W-1:0]  iss_row,
  output logic [RIDX_W-1:0] dst_q,
  output logic [RIDX_W-1:0] src_a_q,
  output logic [RIDX_W-1:0] src_b_q,
  output logic [VL_W-1:0]   vl_cur,
  output logic [VL_W-1:0]   vl_lat,
  output logic              accept,
  output logic              done
);
  seq_state_e state;
  logic [ROW_W-1:0] row;
  logic             p1, p2, p3, done_q;
  logic             iss_last;
  logic [VL_W-1:0]  next_base;

  assign accept    = start && (state == ST_IDLE) && !done_q;
  assign next_base = VL_W'({row, {LANE_W{1'b0}}}) + VL_W'(LANES);
  assign iss_last  = (state == ST_ISSUE) && (next_base >= vl_lat);
  assign iss_row   = row;
  assign done      = done_q;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign iss_mask[l] = (state == ST_ISSUE) &&
                         (VL_W'({row, LANE_W'(l)}) < vl_lat);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      row     <= '0;
      vl_cur  <= VL_W'(MAXVL);
      vl_lat  <= '0;
      dst_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
      p1      <= 1'b0;
      p2      <= 1'b0;
      p3      <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (vl_we)
        vl_cur <= (vl_wdata > VL_W'(MAXVL)) ? VL_W'(MAXVL) : vl_wdata;
      p1     <= iss_last;
      p2     <= p1;
      p3     <= p2;
      done_q <= p3 || (accept && (vl_cur == '0));
      case (state)
        ST_IDLE: begin
          if (accept) begin
            vl_lat  <= vl_cur;
            dst_q   <= dst_in;
            src_a_q <= src_a_in;
            src_b_q <= src_b_in;
            row     <= '0;
            if (vl_cur != '0) state <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (iss_last) state <= ST_DRAIN;
          else          row   <= row + 1'b1;
        end
        ST_DRAIN: begin
          if (p3) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vadd_lane.sv
module vadd_lane #(
  parameter int DW    = 32,
  parameter int NREGS = 8,
  parameter int ROWS  = 16,
  localparam int RIDX_W = $clog2(NREGS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_en,
  input  logic [ROW_W-1:0]  iss_row,
  input  logic [RIDX_W-1:0] src_a,
  input  logic [RIDX_W-1:0] src_b,
  input  logic [RIDX_W-1:0] dst,
  input  logic              tp_we,
  input  logic [RIDX_W-1:0] tp_reg,
  input  logic [ROW_W-1:0]  tp_row,
  input  logic [DW-1:0]     tp_wdata,
  output logic [DW-1:0]     tp_rdata,
  output logic              wb_en,
  output logic [ROW_W-1:0]  wb_row
);
  localparam int AW    = RIDX_W + ROW_W;
  localparam int DEPTH = NREGS * ROWS;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] op_a, op_b, ex_sum, tp_q;
  logic [AW-1:0] rd_wa, ex_wa;
  logic          rd_v, ex_v;

  // storage and data path: no reset, block RAM style
  always_ff @(posedge clk) begin
    op_a   <= mem[{src_a, iss_row}];
    op_b   <= mem[{src_b, iss_row}];
    tp_q   <= mem[{tp_reg, tp_row}];
    rd_wa  <= {dst, iss_row};
    ex_wa  <= rd_wa;
    ex_sum <= op_a + op_b;
    if (ex_v)
      mem[ex_wa] <= ex_sum;
    else if (tp_we)
      mem[{tp_reg, tp_row}] <= tp_wdata;
  end

  // pipeline valid bits
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_v <= 1'b0;
      ex_v <= 1'b0;
    end else begin
      rd_v <= iss_en;
      ex_v <= rd_v;
    end
  end

  assign tp_rdata = tp_q;
  assign wb_en    = ex_v;
  assign wb_row   = ex_wa[ROW_W-1:0];
endmodule

// File: rtl/vadd_lanes.sv
module vadd_lanes
  import vadd_pkg::*;
#(
  parameter int LANES = DEF_LANES,
  parameter int MAXVL = DEF_MAXVL,
  parameter int NREGS = DEF_NREGS,
  parameter int DW    = DEF_DW,
  localparam int VL_W   = $clog2(MAXVL + 1),
  localparam int IDX_W  = $clog2(MAXVL),
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [RIDX_W-1:0] dst,
  input  logic [RIDX_W-1:0] src_a,
  input  logic [RIDX_W-1:0] src_b,
  input  logic              vl_we,
  input  logic [VL_W-1:0]   vl_wdata,
  output logic              done,
  input  logic              tp_we,
  input  logic [RIDX_W-1:0] tp_reg,
  input  logic [IDX_W-1:0]  tp_idx,
  input  logic [DW-1:0]     tp_wdata,
  output logic [DW-1:0]     tp_rdata
);
  localparam int LANE_W = $clog2(LANES);
  localparam int ROWS   = MAXVL / LANES;
  localparam int ROW_W  = $clog2(ROWS);

  logic [LANES-1:0]       iss_mask;
  logic [ROW_W-1:0]       iss_row;
  logic [RIDX_W-1:0]      dst_q, src_a_q, src_b_q;
  logic [VL_W-1:0]        vl_cur, vl_lat;
  logic                   accept;
  logic [DW-1:0]          lane_rd [LANES];
  logic [LANES-1:0]       wb_en_v;
  logic [LANES*ROW_W-1:0] wb_row_flat;
  logic [LANE_W-1:0]      tp_lane, tp_lane_q;
  logic [ROW_W-1:0]       tp_row;

  assign tp_lane = tp_idx[LANE_W-1:0];
  assign tp_row  = tp_idx[IDX_W-1:LANE_W];

  vadd_seq #(.LANES(LANES), .MAXVL(MAXVL), .NREGS(NREGS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dst_in   (dst),
    .src_a_in (src_a),
    .src_b_in (src_b),
    .vl_we    (vl_we),
    .vl_wdata (vl_wdata),
    .iss_mask (iss_mask),
    .iss_row  (iss_row),
    .dst_q    (dst_q),
    .src_a_q  (src_a_q),
    .src_b_q  (src_b_q),
    .vl_cur   (vl_cur),
    .vl_lat   (vl_lat),
    .accept   (accept),
    .done     (done)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vadd_lane #(.DW(DW), .NREGS(NREGS), .ROWS(ROWS)) u_lane (
      .clk      (clk),
      .rst      (rst),
      .iss_en   (iss_mask[l]),
      .iss_row  (iss_row),
      .src_a    (src_a_q),
      .src_b    (src_b_q),
      .dst      (dst_q),
      .tp_we    (tp_we && (tp_lane == LANE_W'(l))),
      .tp_reg   (tp_reg),
      .tp_row   (tp_row),
      .tp_wdata (tp_wdata),
      .tp_rdata (lane_rd[l]),
      .wb_en    (wb_en_v[l]),
      .wb_row   (wb_row_flat[l*ROW_W +: ROW_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) tp_lane_q <= '0;
    else     tp_lane_q <= tp_lane;
  end

  assign tp_rdata = lane_rd[tp_lane_q];
endmodule

// File: rtl/vadd_lanes_chk.sv
module vadd_lanes_chk #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  localparam int LANE_W = $clog2(LANES),
  localparam int ROW_W  = $clog2(MAXVL / LANES),
  localparam int VL_W   = $clog2(MAXVL + 1)
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   accept,
  input logic [VL_W-1:0]        vl_cur,
  input logic [VL_W-1:0]        vl_lat,
  input logic                   done,
  input logic [LANES-1:0]       wb_en,
  input logic [LANES*ROW_W-1:0] wb_row
);
  logic [15:0] cnt, exp_lat;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      exp_lat <= '0;
    end else if (accept) begin
      cnt     <= '0;
      exp_lat <= (vl_cur == '0) ? 16'd0
               : 16'(((vl_cur - 1'b1) >> LANE_W)) + 16'd4;
    end else if (cnt != 16'hFFFF) begin
      cnt <= cnt + 16'd1;
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (cnt == exp_lat));

  // R5
  zero_len_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && (vl_cur == '0)) |=> done);

  for (genvar l = 0; l < LANES; l++) begin : g_wb
    // R3
    wb_range_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en[l] |-> (VL_W'({wb_row[l*ROW_W +: ROW_W], LANE_W'(l)}) < vl_lat));
  end
endmodule

bind vadd_lanes vadd_lanes_chk #(.LANES(LANES), .MAXVL(MAXVL)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .accept (accept),
  .vl_cur (vl_cur),
  .vl_lat (vl_lat),
  .done   (done),
  .wb_en  (wb_en_v),
  .wb_row (wb_row_flat)
);

// File: tb/vadd_lanes_bench.sv
module vadd_lanes_bench;
  localparam int LANES = 4;
  localparam int MAXVL = 64;
  localparam int NREGS = 8;

  logic        clk = 1'b0;
  logic        rst, start, vl_we, tp_we, done;
  logic [2:0]  dst, src_a, src_b, tp_reg;
  logic [6:0]  vl_wdata;
  logic [5:0]  tp_idx;
  logic [31:0] tp_wdata, tp_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] model [NREGS][MAXVL];

  always #5 clk = ~clk;

  vadd_lanes u_vadd_lanes (
    .clk(clk), .rst(rst), .start(start), .dst(dst), .src_a(src_a),
    .src_b(src_b), .vl_we(vl_we), .vl_wdata(vl_wdata), .done(done),
    .tp_we(tp_we), .tp_reg(tp_reg), .tp_idx(tp_idx), .tp_wdata(tp_wdata),
    .tp_rdata(tp_rdata)
  );

  function automatic logic [31:0] pat(int r, int i);
    return 32'(r) * 32'h0100_0193 + 32'(i) * 32'h9E37_79B1 + 32'hF000_0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tp_write(input int r, input int i, input logic [31:0] d);
    @(negedge clk);
    tp_we = 1'b1; tp_reg = 3'(r); tp_idx = 6'(i); tp_wdata = d;
    @(negedge clk);
    tp_we = 1'b0;
  endtask

  task automatic tp_read(input int r, input int i, output logic [31:0] d);
    @(negedge clk);
    tp_reg = 3'(r); tp_idx = 6'(i);
    @(negedge clk);
    d = tp_rdata;
  endtask

  task automatic set_vl(input int v);
    @(negedge clk);
    vl_we = 1'b1; vl_wdata = 7'(v);
    @(negedge clk);
    vl_we = 1'b0;
  endtask

  task automatic check_reg(input int r, input int lim, input string tag);
    logic [31:0] got;
    for (int i = 0; i < MAXVL; i++) begin
      tp_read(r, i, got);
      chk(got == model[r][i], (i < lim) ? tag : "R3", got, model[r][i]);
    end
  endtask

  task automatic run_op(input int d, input int a, input int b, input int vl_used,
                        input bit poke, input int ig_dst,
                        input bit vl_mid, input int vl_mid_val,
                        input bit vl_same, input int vl_same_val,
                        input string tag);
    int j;
    int exp_lat;
    logic [31:0] nv [MAXVL];
    @(negedge clk);
    start = 1'b1; dst = 3'(d); src_a = 3'(a); src_b = 3'(b);
    vl_we = vl_same; vl_wdata = 7'(vl_same_val);
    @(negedge clk);
    start = 1'b0; vl_we = 1'b0;
    j = 0;
    while (!done && j < 200) begin
      start    = poke && (j == 2);
      dst      = poke ? 3'(ig_dst) : 3'(d);
      vl_we    = vl_mid && (j == 1);
      vl_wdata = 7'(vl_mid_val);
      @(negedge clk);
      j++;
    end
    start = 1'b0; vl_we = 1'b0;
    exp_lat = (vl_used == 0) ? 0 : (vl_used + LANES - 1) / LANES + 3;
    chk(j == exp_lat, (vl_used == 0) ? "R5 latency" : "R4 latency",
        32'(j), 32'(exp_lat));
    // stray start in the done cycle must be ignored (R7)
    if (poke) begin start = 1'b1; dst = 3'(ig_dst); end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R4 pulse", {31'd0, done}, 32'd0);
    for (int i = 0; i < MAXVL; i++)
      nv[i] = (i < vl_used) ? model[a][i] + model[b][i] : model[d][i];
    for (int i = 0; i < MAXVL; i++) model[d][i] = nv[i];
    check_reg(d, vl_used, tag);
    if (poke) check_reg(ig_dst, 0, "R7");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R4 act=0 exp=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got;
    rst = 1'b1; start = 1'b0; vl_we = 1'b0; tp_we = 1'b0;
    dst = '0; src_a = '0; src_b = '0; vl_wdata = '0;
    tp_reg = '0; tp_idx = '0; tp_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R9 done idle", {31'd0, done}, 32'd0);

    // preload every element and read it back (R1)
    for (int r = 0; r < NREGS; r++)
      for (int i = 0; i < MAXVL; i++) begin
        model[r][i] = (r == 7 && i < 16) ? 32'hFFFF_FFFF : pat(r, i);
        tp_write(r, i, model[r][i]);
      end
    for (int r = 0; r < NREGS; r++)
      for (int i = 0; i < MAXVL; i++) begin
        tp_read(r, i, got);
        chk(got == model[r][i], "R1 readback", got, model[r][i]);
      end

    // reset length is full (R9), full-length add (R2)
    run_op(2, 0, 1, 64, 0, 0, 0, 0, 0, 0, "R9 R2");
    set_vl(0);
    run_op(3, 4, 5, 0, 0, 0, 0, 0, 0, 0, "R5");
    set_vl(1);
    run_op(4, 2, 3, 1, 0, 0, 0, 0, 0, 0, "R2");
    set_vl(5);
    run_op(5, 6, 7, 5, 0, 0, 0, 0, 0, 0, "R2");
    set_vl(63);
    run_op(1, 7, 2, 63, 0, 0, 0, 0, 0, 0, "R2");
    set_vl(4);
    run_op(0, 1, 7, 4, 0, 0, 0, 0, 0, 0, "R2");
    set_vl(37);
    run_op(6, 6, 6, 37, 0, 0, 0, 0, 0, 0, "R10");
    set_vl(22);
    run_op(3, 3, 7, 22, 0, 0, 0, 0, 0, 0, "R10");
    set_vl(100);
    run_op(0, 1, 2, 64, 0, 0, 0, 0, 0, 0, "R6");
    set_vl(20);
    run_op(3, 0, 5, 20, 1, 4, 0, 0, 0, 0, "R7");
    set_vl(10);
    run_op(2, 3, 4, 10, 0, 0, 1, 60, 0, 0, "R8");
    run_op(5, 1, 1, 60, 0, 0, 0, 0, 0, 0, "R8");
    run_op(4, 6, 0, 60, 0, 0, 0, 0, 1, 3, "R8");
    run_op(1, 2, 2, 3, 0, 0, 0, 0, 0, 0, "R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule